// File: doc/BRIEF.md
# Add/Subtract Reservation Station Bank

This block is the scheduling front of the integer add/subtract unit in an out-of-order core that has no reorder buffer. It holds three reservation stations. The issue logic writes an instruction into a station it names by index. Each source operand arrives either as a value or as the tag of the station that will produce it. While an operand is pending, the station watches the shared result bus and copies the value when the matching tag appears.

Once a station holds both operands, it may be sent to the single execution unit. Station 0 has the highest priority and station 2 the lowest. The unit takes two cycles to add or subtract. It then offers the result, tagged with its station number, to the bus arbiter. The multiply unit wins any conflict on the bus. A result that loses is held unchanged until it is granted. The unit accepts no further dispatch while it holds a result. A station becomes free at the end of the cycle in which its result is granted.

Issue is a valid/ready handshake. `issue_ready` is high exactly when the station selected by `issue_idx` is free. An offer with `issue_ready` low is dropped. The result port is also valid/ready. `bc_valid` stays high, with tag and data held stable, until a cycle in which `bc_ready` is high. Tag encoding: 0, 1 and 2 name this bank's stations, 7 means "no tag, the value field is valid", and any other tag belongs to another unit.

Top module: `addsub_rs_bank`

## Requirements
- R1: After reset, all three stations are free (`rs_free` = 3'b111), `bc_valid` is low, and `issue_ready` is high for every index 0 to 2.
- R2: An issue takes effect only in a cycle with `issue_valid` and `issue_ready` both high. `issue_ready` is low while the station selected by `issue_idx` is busy. An offer to a busy station does not change that station, so its later result is unchanged.
- R3: When several stations are ready in the same cycle and the unit is idle, station 0 dispatches before station 1, and station 1 before station 2.
- R4: An instruction is not dispatched in the cycle it is written. With both operands valid and the unit idle, an instruction issued in cycle c has its result on `bc_valid` first in cycle c+4.
- R5: A station whose Qj or Qk equals the tag on a valid bus cycle copies `bus_data` into that operand. This also applies to an instruction issued in that same cycle. An operand captured in cycle b does not allow dispatch in cycle b, so the earliest result appears in cycle b+4.
- R6: The result is Vj+Vk for op 0 and Vj−Vk for op 1, in 32-bit two's complement, with overflow wrapping. It first appears exactly 3 cycles after the dispatch cycle.
- R7: While `bc_valid` is high and `bc_ready` is low, `bc_valid` stays high and `bc_tag` and `bc_data` stay stable, and no other station is dispatched.
- R8: A station whose result is granted in cycle g still reads busy in cycle g (its `rs_free` bit is 0 and `issue_ready` is low for it). It reads free from cycle g+1.
- R9: `bc_tag` equals the index of the station the result came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue offer valid |
| issue_ready | output | 1 | Selected station is free |
| issue_idx | input | 2 | Target station index (0 to 2) |
| issue_op | input | 1 | 0 = add, 1 = subtract |
| issue_vj | input | 32 | First operand value |
| issue_vk | input | 32 | Second operand value |
| issue_qj | input | 3 | First operand producer tag, 7 = value valid |
| issue_qk | input | 3 | Second operand producer tag, 7 = value valid |
| rs_free | output | 3 | One bit per station, 1 = free |
| bus_valid | input | 1 | Result bus carries a value this cycle |
| bus_tag | input | 3 | Producer tag on the result bus |
| bus_data | input | 32 | Value on the result bus |
| bc_valid | output | 1 | Result waiting for the bus |
| bc_ready | input | 1 | Bus granted to this unit |
| bc_tag | output | 3 | Station tag of the result |
| bc_data | output | 32 | Result value |

## Verification
The bench aims at the exact cycle of the first result after issue and after capture. A design that dispatched in the cycle of a write or a capture would present its result one cycle early. Three stations released by one bus value must report in the order 0, 1, 2, while a blocked result is held for several cycles; an inverted priority, or data that changes while blocked, shows up directly in the tags and values. The free bit is watched in the grant cycle and the cycle after, so a station handed out too early is caught. An issue whose operand tag is on the bus in the same cycle checks that the value is not lost. A rejected issue to a busy station checks that the later result is still the original one. Random traffic with chained dependencies and random bus blocking checks every result against values the bench computes.

// File: rtl/addsub_rs_pkg.sv
package addsub_rs_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/addsub_rs_entry.sv
module addsub_rs_entry
  import addsub_rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] NO_TAG = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  op_e               wr_op,
  input  logic [DATA_W-1:0] wr_vj,
  input  logic [DATA_W-1:0] wr_vk,
  input  logic [TAG_W-1:0]  wr_qj,
  input  logic [TAG_W-1:0]  wr_qk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              disp_en,
  input  logic              free_en,
  output logic              busy,
  output logic              ready,
  output op_e               op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  logic             sent_q;
  logic [TAG_W-1:0] qj_q, qk_q;
  logic             hit_j, hit_k;

  assign hit_j = busy && bus_valid && (qj_q != NO_TAG) && (qj_q == bus_tag);
  assign hit_k = busy && bus_valid && (qk_q != NO_TAG) && (qk_q == bus_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sent_q <= 1'b0;
      op     <= OP_ADD;
      vj     <= '0;
      vk     <= '0;
      qj_q   <= NO_TAG;
      qk_q   <= NO_TAG;
    end else if (free_en) begin
      busy   <= 1'b0;
      sent_q <= 1'b0;
      qj_q   <= NO_TAG;
      qk_q   <= NO_TAG;
    end else if (wr_en) begin
      busy   <= 1'b1;
      sent_q <= 1'b0;
      op     <= wr_op;
      vj     <= wr_vj;
      vk     <= wr_vk;
      qj_q   <= wr_qj;
      qk_q   <= wr_qk;
    end else begin
      if (disp_en) sent_q <= 1'b1;
      if (hit_j) begin
        vj   <= bus_data;
        qj_q <= NO_TAG;
      end
      if (hit_k) begin
        vk   <= bus_data;
        qk_q <= NO_TAG;
      end
    end
  end

  assign ready = busy && !sent_q && (qj_q == NO_TAG) && (qk_q == NO_TAG);

  // R2: writes land only in a free station
  p_write_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);
  // R4: no dispatch in the cycle of a write
  p_no_disp_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (busy && !wr_en));
  // R5: no dispatch while an operand is being captured
  p_no_disp_on_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !(hit_j || hit_k));
  // R8: release only of a dispatched station, and it reads free afterwards
  p_free_sent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> (busy && sent_q));
  p_free_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> !busy);
endmodule

// File: rtl/addsub_rs_picker.sv
module addsub_rs_picker #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      if (en && req[i] && (gnt == '0)) gnt[i] = 1'b1;
    end
  end

  assign any = |gnt;

  // R3: at most one grant, and never past a lower-index request
  always_comb begin
    p_onehot_grant_r3: assert ($onehot0(gnt));
    for (int i = 1; i < N; i++) begin
      if (gnt[i]) p_lowest_first_r3: assert ((req & ((N)'(1) << i) - 1'b1) == '0 || !en);
    end
  end
endmodule

// File: rtl/addsub_rs_exec.sv
module addsub_rs_exec
  import addsub_rs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 3,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               start_op,
  input  logic [DATA_W-1:0] start_a,
  input  logic [DATA_W-1:0] start_b,
  input  logic [TAG_W-1:0]  start_tag,
  output logic              idle,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  op_e               op_q;
  logic [DATA_W-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      op_q      <= OP_ADD;
      a_q       <= '0;
      b_q       <= '0;
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= CNT_W'(LATENCY - 1);
      op_q    <= start_op;
      a_q     <= start_a;
      b_q     <= start_b;
      res_tag <= start_tag;
    end else if (busy_q && !res_valid) begin
      if (cnt_q == '0) begin
        res_valid <= 1'b1;
        res_data  <= (op_q == OP_SUB) ? (a_q - b_q) : (a_q + b_q);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
      busy_q    <= 1'b0;
    end
  end

  assign idle = !busy_q;

  // independent cycle count since the last start, for the latency check
  logic [15:0] since_start;
  always_ff @(posedge clk) begin
    if (!rst_n) since_start <= '0;
    else if (start) since_start <= '0;
    else if (since_start != 16'hFFFF) since_start <= since_start + 1'b1;
  end

  // R6: result appears LATENCY+1 cycles after the dispatch cycle
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (since_start == 16'(LATENCY)));
  // R7: a blocked result is held unchanged
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_tag)));
  // R7: no new dispatch while the unit is occupied
  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R8: granted result leaves the port
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);
endmodule

// File: rtl/addsub_rs_bank.sv
module addsub_rs_bank
  import addsub_rs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 3,
  parameter int NUM_RS  = 3,
  parameter int LATENCY = 2,
  localparam int IDX_W  = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic              issue_op,
  input  logic [DATA_W-1:0] issue_vj,
  input  logic [DATA_W-1:0] issue_vk,
  input  logic [TAG_W-1:0]  issue_qj,
  input  logic [TAG_W-1:0]  issue_qk,
  output logic [NUM_RS-1:0] rs_free,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bc_valid,
  input  logic              bc_ready,
  output logic [TAG_W-1:0]  bc_tag,
  output logic [DATA_W-1:0] bc_data
);
  localparam logic [TAG_W-1:0] NO_TAG = '1;

  logic [NUM_RS-1:0] busy, ready, wr_en, gnt, free_en;
  op_e               st_op [NUM_RS];
  logic [DATA_W-1:0] st_vj [NUM_RS];
  logic [DATA_W-1:0] st_vk [NUM_RS];
  logic              fire, start, exec_idle;
  logic [DATA_W-1:0] in_vj, in_vk;
  logic [TAG_W-1:0]  in_qj, in_qk;
  op_e               d_op;
  logic [DATA_W-1:0] d_a, d_b;
  logic [TAG_W-1:0]  d_tag;

  always_comb begin
    issue_ready = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (issue_idx == IDX_W'(i)) issue_ready = !busy[i];
    end
  end
  assign fire = issue_valid && issue_ready;

  // operands whose producer is broadcasting right now are taken at issue
  always_comb begin
    in_vj = issue_vj;
    in_qj = issue_qj;
    in_vk = issue_vk;
    in_qk = issue_qk;
    if (bus_valid && issue_qj != NO_TAG && issue_qj == bus_tag) begin
      in_vj = bus_data;
      in_qj = NO_TAG;
    end
    if (bus_valid && issue_qk != NO_TAG && issue_qk == bus_tag) begin
      in_vk = bus_data;
      in_qk = NO_TAG;
    end
  end

  for (genvar g = 0; g < NUM_RS; g++) begin : g_st
    assign wr_en[g]   = fire && (issue_idx == IDX_W'(g));
    assign free_en[g] = bc_valid && bc_ready && (bc_tag == TAG_W'(g));
    addsub_rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .NO_TAG(NO_TAG)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[g]), .wr_op(op_e'(issue_op)),
      .wr_vj(in_vj), .wr_vk(in_vk), .wr_qj(in_qj), .wr_qk(in_qk),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .disp_en(gnt[g]), .free_en(free_en[g]),
      .busy(busy[g]), .ready(ready[g]),
      .op(st_op[g]), .vj(st_vj[g]), .vk(st_vk[g])
    );
  end

  assign rs_free = ~busy;

  addsub_rs_picker #(.N(NUM_RS)) u_pick (
    .req(ready), .en(exec_idle), .gnt(gnt), .any(start)
  );

  always_comb begin
    d_op  = OP_ADD;
    d_a   = '0;
    d_b   = '0;
    d_tag = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (gnt[i]) begin
        d_op  = st_op[i];
        d_a   = st_vj[i];
        d_b   = st_vk[i];
        d_tag = TAG_W'(i);
      end
    end
  end

  addsub_rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LATENCY(LATENCY)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_op(d_op), .start_a(d_a), .start_b(d_b), .start_tag(d_tag),
    .idle(exec_idle),
    .res_valid(bc_valid), .res_ready(bc_ready), .res_tag(bc_tag), .res_data(bc_data)
  );

  // R9: results carry the tag of a station in this bank that is still busy
  p_tag_in_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> ((bc_tag < TAG_W'(NUM_RS)) && (busy[bc_tag[IDX_W-1:0]])));
  // R2: ready mirrors the free flag of the addressed station
  p_ready_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_idx < IDX_W'(NUM_RS)) |-> (issue_ready == rs_free[issue_idx]));
endmodule

// File: tb/addsub_rs_bank_test.sv
module addsub_rs_bank_test;
  localparam int PERIOD = 10;
  localparam logic [2:0] NO = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_ready;
  logic [1:0]  issue_idx;
  logic        issue_op;
  logic [31:0] issue_vj, issue_vk;
  logic [2:0]  issue_qj, issue_qk;
  logic [2:0]  rs_free;
  logic        bus_valid;
  logic [2:0]  bus_tag;
  logic [31:0] bus_data;
  logic        bc_valid, bc_ready;
  logic [2:0]  bc_tag;
  logic [31:0] bc_data;
  logic        mul_v;
  logic [2:0]  mul_tag;
  logic [31:0] mul_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_val [3];

  always #(PERIOD/2) clk = ~clk;

  // bus arbiter: the multiply side always wins
  assign bc_ready  = !mul_v;
  assign bus_valid = mul_v || bc_valid;
  assign bus_tag   = mul_v ? mul_tag  : bc_tag;
  assign bus_data  = mul_v ? mul_data : bc_data;

  addsub_rs_bank uut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_idx(issue_idx),
    .issue_op(issue_op), .issue_vj(issue_vj), .issue_vk(issue_vk),
    .issue_qj(issue_qj), .issue_qk(issue_qk), .rs_free(rs_free),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_tag(bc_tag), .bc_data(bc_data)
  );

  function automatic logic [31:0] model(logic op, logic [31:0] a, logic [31:0] b);
    return op ? (a - b) : (a + b);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    issue_valid = 0; issue_idx = 0; issue_op = 0;
    issue_vj = 0; issue_vk = 0; issue_qj = NO; issue_qk = NO;
    mul_v = 0; mul_tag = 3'd3; mul_data = 0;
  endtask

  task automatic put(input logic [1:0] idx, input logic op, input logic [31:0] vj,
                     input logic [31:0] vk, input logic [2:0] qj, input logic [2:0] qk);
    issue_valid = 1; issue_idx = idx; issue_op = op;
    issue_vj = vj; issue_vk = vk; issue_qj = qj; issue_qk = qk;
  endtask

  // wait for a granted broadcast; returns its tag, data and cycles waited
  task automatic wait_bc(output logic [2:0] t, output logic [31:0] d, output int n);
    n = 0;
    forever begin
      #1;
      if (bc_valid && bc_ready) begin
        t = bc_tag; d = bc_data;
        nxt();
        return;
      end
      nxt();
      n++;
      if (n > 60) begin
        chk(0, "R7 result never granted", 0, 1);
        t = 0; d = 0;
        return;
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [2:0]  t;
    logic [31:0] d;
    int          n;
    idle_inputs();
    rst_n = 0;
    repeat (3) nxt();
    rst_n = 1;
    nxt();

    // R1: reset state
    #1;
    chk(rs_free == 3'b111, "R1 rs_free", 32'(rs_free), 32'h7);
    chk(!bc_valid, "R1 bc_valid", 32'(bc_valid), 0);
    for (int i = 0; i < 3; i++) begin
      issue_idx = 2'(i); #1;
      chk(issue_ready, "R1 issue_ready", 32'(issue_ready), 1);
    end
    nxt();

    // R4/R6/R8/R9: issue with ready operands into station 1, exact timing
    put(2'd1, 1'b0, 32'd5, 32'd7, NO, NO);
    #1; chk(issue_ready, "R2 accept free station", 32'(issue_ready), 1);
    nxt(); idle_inputs();
    for (int k = 1; k <= 3; k++) begin
      #1; chk(!bc_valid, "R4 no early result", 32'(bc_valid), 0);
      nxt();
    end
    #1;
    chk(bc_valid, "R4 result at c+4", 32'(bc_valid), 1);
    chk(bc_tag == 3'd1, "R9 tag", 32'(bc_tag), 1);
    chk(bc_data == 32'd12, "R6 add value", bc_data, 12);
    chk(rs_free[1] == 1'b0, "R8 busy in grant cycle", 32'(rs_free[1]), 0);
    issue_idx = 2'd1; #1;
    chk(!issue_ready, "R8 not reusable in grant cycle", 32'(issue_ready), 0);
    nxt();
    #1; chk(rs_free[1] == 1'b1, "R8 free after grant", 32'(rs_free[1]), 1);
    nxt();

    // R3/R5/R2/R7: three stations released by one bus value
    put(2'd2, 1'b0, 32'd10, 32'd0, NO, 3'd4); nxt();
    put(2'd1, 1'b1, 32'd100, 32'd0, NO, 3'd4); nxt();
    put(2'd0, 1'b0, 32'd1, 32'd0, NO, 3'd4); nxt();
    put(2'd2, 1'b1, 32'hDEAD, 32'h1, NO, NO);
    #1; chk(!issue_ready, "R2 busy station refuses", 32'(issue_ready), 0);
    nxt(); idle_inputs();
    mul_v = 1; mul_tag = 3'd4; mul_data = 32'd50;
    nxt();
    mul_v = 0;
    for (int k = 1; k <= 3; k++) begin
      #1; chk(!bc_valid, "R5 no dispatch on capture", 32'(bc_valid), 0);
      nxt();
    end
    #1; chk(bc_valid, "R5 result at b+4", 32'(bc_valid), 1);
    // block the bus for three cycles with a foreign tag
    mul_v = 1; mul_tag = 3'd3; mul_data = 32'h1234;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(bc_valid && bc_data == 32'd51, "R7 held value", bc_data, 51);
      chk(bc_tag == 3'd0, "R3 first is station 0", 32'(bc_tag), 0);
      nxt();
    end
    mul_v = 0;
    wait_bc(t, d, n);
    chk(t == 3'd0 && d == 32'd51, "R3 station 0 result", d, 51);
    wait_bc(t, d, n);
    chk(t == 3'd1, "R3 second is station 1", 32'(t), 1);
    chk(d == 32'd50, "R6 sub value", d, 50);
    wait_bc(t, d, n);
    chk(t == 3'd2, "R3 third is station 2", 32'(t), 2);
    chk(d == 32'd60, "R2 refused issue left no trace", d, 60);

    // R5 capture at issue, R6 wrap
    put(2'd0, 1'b0, 32'd0, 32'd5, 3'd3, NO);
    mul_v = 1; mul_tag = 3'd3; mul_data = 32'd1000;
    nxt(); idle_inputs();
    put(2'd1, 1'b1, 32'd0, 32'd1, NO, NO); nxt();
    put(2'd2, 1'b0, 32'hFFFF_FFFF, 32'd2, NO, NO); nxt();
    idle_inputs();
    wait_bc(t, d, n);
    chk(t == 3'd0 && d == 32'd1005, "R5 capture at issue", d, 1005);
    wait_bc(t, d, n);
    chk(t == 3'd1 && d == 32'hFFFF_FFFF, "R6 sub wraps", d, 32'hFFFF_FFFF);
    wait_bc(t, d, n);
    chk(t == 3'd2 && d == 32'd1, "R6 add wraps", d, 1);

    // random traffic with dependencies and bus blocking
    begin
      int seed_dummy;
      bit          held;
      logic [31:0] held_d;
      logic [2:0]  held_t;
      seed_dummy = $urandom(32'hC0FFEE);
      held = 0; held_d = 0; held_t = 0;
      for (int cyc = 0; cyc < 400; cyc++) begin
        logic [1:0]  idx;
        logic        op;
        logic [31:0] a, b;
        logic [2:0]  qj;
        int          dep;
        idle_inputs();
        mul_v = ($urandom % 4 == 0);
        mul_tag = ($urandom % 2 == 0) ? 3'd3 : 3'd4;
        mul_data = $urandom;
        idx = 2'($urandom % 3);
        op = 1'($urandom);
        a = ($urandom % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
        b = ($urandom % 5 == 0) ? 32'h8000_0000 : $urandom;
        qj = NO; dep = -1;
        if ($urandom % 3 == 0) begin
          for (int j = 0; j < 3; j++)
            if (dep < 0 && j != int'(idx) && !rs_free[j]) dep = j;
        end
        if (dep >= 0) qj = 3'(dep);
        if ($urandom % 3 != 0 && cyc < 360) put(idx, op, a, b, qj, NO);
        #1;
        if (held) chk(bc_valid && bc_data == held_d && bc_tag == held_t,
                      "R7 random hold", bc_data, held_d);
        held = bc_valid && !bc_ready;
        held_d = bc_data; held_t = bc_tag;
        if (bc_valid && bc_ready)
          chk(bc_data == exp_val[bc_tag[1:0]], "R6 random result", bc_data, exp_val[bc_tag[1:0]]);
        if (issue_valid && issue_ready)
          exp_val[idx] = model(op, (dep >= 0) ? exp_val[dep] : a, b);
        nxt();
      end
      idle_inputs();
      for (int k = 0; k < 100 && !(rs_free == 3'b111 && !bc_valid); k++) begin
        #1;
        if (bc_valid && bc_ready)
          chk(bc_data == exp_val[bc_tag[1:0]], "R6 drain result", bc_data, exp_val[bc_tag[1:0]]);
        nxt();
      end
      #1; chk(rs_free == 3'b111, "R8 all free after drain", 32'(rs_free), 7);
    end
    finish_run();
  end
endmodule